// File: doc/BRIEF.md
# Display Adapter Indexed Register Bank

This block is the register bank of a display adapter as software sees it through a small window of 32-bit I/O ports. Software first writes a register number to the selector port. The data port then reads or writes the register chosen. The bank holds the mode settings: enable, horizontal and vertical resolution, and colour depth in bits per pixel. It also holds the adapter identification handshake, a configuration-complete flag, a synchronisation strobe, the hardware cursor state and a scratch RAM that software can use freely.

Several registers do not read back what was stored in them. Colour depth, line pitch, capabilities and limits are computed when they are read. Writes that fall outside the allowed range are dropped without any effect. The cursor visibility register follows a set/clear rule in which some codes leave the flag unchanged. Register numbers in the colour-map window are tolerated but do nothing. Any other unknown register number sets a sticky error flag.

Read data is returned one clock after the access, qualified by a valid strobe. Writes take effect on the clock edge that accepts them.

Top module: `dispreg_port`

## Requirements
- R1: The port offset selects the function. Offset 0 reads and writes the selector. Offset 1 reads and writes the selected register. Offset 2 reads zero and ignores writes. Offset 3 reads 0xFFFFFFFF and ignores writes. Read data and `rd_valid` appear in the cycle after a read access.
- R2: Register 0 (identification) resets to 0x90000002. It accepts only 0x90000000, 0x90000001 and 0x90000002. Any other written value leaves it unchanged.
- R3: A write to register 2 (width) is kept only when it is at most MAX_W. A write to register 3 (height) is kept only when it is at most MAX_H. Both values are driven on `mode_width` and `mode_height`.
- R4: Register 7 (bits per pixel) accepts only 8, 16, 24 or 32. Register 6 (depth) reads 24 when bits per pixel is 32, and reads the bits per pixel otherwise.
- R5: Register 12 (line pitch) reads bits-per-pixel × width / 8.
- R6: A write to register 27 (cursor visible) sets the flag when the value is 1 and clears it when the value is 0. Any other value leaves the flag unchanged. The flag is driven on `cursor_on`.
- R7: Registers 1792 to 1792+SCR_DEPTH−1 form a read/write scratch RAM.
- R8: Registers 1024 to 1791 read zero, ignore writes and do not set `bad_reg`.
- R9: A write to register 21 raises `sync_pulse` for exactly the next cycle. Register 20 stores whether the written value was nonzero and drives `config_done`. Register 1 does the same for `mode_enable`.
- R10: Register 17 reads 3 (fill and copy supported). Registers 4 and 5 read MAX_W and MAX_H. Register 29 reads SCR_DEPTH.
- R11: A data-port access to any other register number reads zero and changes no state. This includes scratch numbers past the end of the RAM, which must not alias into it. Such an access sets `bad_reg`, which stays set until reset.
- R12: After reset the selector is 0, width is RST_W, height is RST_H, bits per pixel is 32, and the enable, config, cursor, sync and error outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 2 | Port offset within the window |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High the cycle after a read access |
| mode_enable | output | 1 | Adapter mode enabled |
| mode_width | output | $clog2(MAX_W+1) | Horizontal resolution |
| mode_height | output | $clog2(MAX_H+1) | Vertical resolution |
| mode_bpp | output | 6 | Bits per pixel |
| config_done | output | 1 | Configuration-complete flag |
| sync_pulse | output | 1 | One-cycle command-processing request |
| cursor_on | output | 1 | Cursor visible |
| cursor_id | output | 32 | Cursor identifier |
| cursor_x | output | 32 | Cursor column |
| cursor_y | output | 32 | Cursor row |
| bad_reg | output | 1 | Sticky flag for an undefined register number |

## Verification
Every read result becomes due exactly one clock after the access cycle. This holds for control registers, the scratch RAM and the constant offsets alike. The bench therefore drives each access on a falling edge, holds it for one cycle and samples `rd_data` on the falling edge that follows. Register writes, the sticky error flag and the mode outputs all settle on the edge that accepts the write, so they are checked at that same falling edge. `sync_pulse` is checked high at that edge and low one cycle later.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;

  // Register numbers decoded by software drivers; values are fixed.
  localparam logic [31:0] IX_ID       = 32'd0;
  localparam logic [31:0] IX_ENABLE   = 32'd1;
  localparam logic [31:0] IX_WIDTH    = 32'd2;
  localparam logic [31:0] IX_HEIGHT   = 32'd3;
  localparam logic [31:0] IX_MAXW     = 32'd4;
  localparam logic [31:0] IX_MAXH     = 32'd5;
  localparam logic [31:0] IX_DEPTH    = 32'd6;
  localparam logic [31:0] IX_BPP      = 32'd7;
  localparam logic [31:0] IX_PITCH    = 32'd12;
  localparam logic [31:0] IX_CAPS     = 32'd17;
  localparam logic [31:0] IX_CFG      = 32'd20;
  localparam logic [31:0] IX_SYNC     = 32'd21;
  localparam logic [31:0] IX_BUSY     = 32'd22;
  localparam logic [31:0] IX_GUEST    = 32'd23;
  localparam logic [31:0] IX_CUR_ID   = 32'd24;
  localparam logic [31:0] IX_CUR_X    = 32'd25;
  localparam logic [31:0] IX_CUR_Y    = 32'd26;
  localparam logic [31:0] IX_CUR_ON   = 32'd27;
  localparam logic [31:0] IX_SCR_SIZE = 32'd29;
  localparam logic [31:0] IX_PAL_LO   = 32'd1024;
  localparam logic [31:0] IX_PAL_HI   = 32'd1791;
  localparam logic [31:0] IX_SCR_BASE = 32'd1792;

  localparam logic [31:0] MAGIC_V0 = 32'h9000_0000;
  localparam logic [31:0] MAGIC_V1 = 32'h9000_0001;
  localparam logic [31:0] MAGIC_V2 = 32'h9000_0002;

  localparam logic [31:0] CAP_WORD = 32'h0000_0003; // bit0 fill, bit1 copy

  localparam logic [1:0] OFF_SEL  = 2'd0;
  localparam logic [1:0] OFF_DATA = 2'd1;
  localparam logic [1:0] OFF_BOOT = 2'd2;

  typedef enum logic [1:0] {
    K_CTRL = 2'd0,
    K_PAL  = 2'd1,
    K_SCR  = 2'd2,
    K_BAD  = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/dispreg_decode.sv
module dispreg_decode
  import dispreg_pkg::*;
#(
  parameter int SCR_DEPTH = 64,
  localparam int SCR_AW = (SCR_DEPTH > 1) ? $clog2(SCR_DEPTH) : 1
) (
  input  logic [31:0]       idx,
  output reg_kind_e         kind,
  output logic [SCR_AW-1:0] scr_addr
);

  logic is_ctrl;

  always_comb begin
    case (idx)
      IX_ID, IX_ENABLE, IX_WIDTH, IX_HEIGHT, IX_MAXW, IX_MAXH, IX_DEPTH,
      IX_BPP, IX_PITCH, IX_CAPS, IX_CFG, IX_SYNC, IX_BUSY, IX_GUEST,
      IX_CUR_ID, IX_CUR_X, IX_CUR_Y, IX_CUR_ON, IX_SCR_SIZE: is_ctrl = 1'b1;
      default: is_ctrl = 1'b0;
    endcase
  end

  always_comb begin
    if (is_ctrl)
      kind = K_CTRL;
    else if (idx >= IX_PAL_LO && idx <= IX_PAL_HI)
      kind = K_PAL;
    else if (idx >= IX_SCR_BASE && idx < IX_SCR_BASE + 32'(SCR_DEPTH))
      kind = K_SCR;
    else
      kind = K_BAD;
  end

  assign scr_addr = SCR_AW'(idx - IX_SCR_BASE);

endmodule

// File: rtl/dispreg_scratch.sv
module dispreg_scratch #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  // Single port, registered read: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end

endmodule

// File: rtl/dispreg_ctrl.sv
module dispreg_ctrl
  import dispreg_pkg::*;
#(
  parameter int MAX_W     = 2368,
  parameter int MAX_H     = 1770,
  parameter int RST_W     = 640,
  parameter int RST_H     = 480,
  parameter int SCR_DEPTH = 64,
  localparam int WB = $clog2(MAX_W + 1),
  localparam int HB = $clog2(MAX_H + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [31:0]   idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          mode_enable,
  output logic [WB-1:0] mode_width,
  output logic [HB-1:0] mode_height,
  output logic [5:0]    mode_bpp,
  output logic          config_done,
  output logic          sync_pulse,
  output logic          cursor_on,
  output logic [31:0]   cursor_id,
  output logic [31:0]   cursor_x,
  output logic [31:0]   cursor_y
);

  logic [31:0] id_q;
  logic [31:0] guest_q;
  logic [31:0] pitch;

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q        <= MAGIC_V2;
      mode_enable <= 1'b0;
      mode_width  <= WB'(RST_W);
      mode_height <= HB'(RST_H);
      mode_bpp    <= 6'd32;
      config_done <= 1'b0;
      sync_pulse  <= 1'b0;
      guest_q     <= '0;
      cursor_on   <= 1'b0;
      cursor_id   <= '0;
      cursor_x    <= '0;
      cursor_y    <= '0;
    end else begin
      sync_pulse <= wr_en && (idx == IX_SYNC);
      if (wr_en) begin
        case (idx)
          IX_ID:
            if (wdata == MAGIC_V0 || wdata == MAGIC_V1 || wdata == MAGIC_V2)
              id_q <= wdata;
          IX_ENABLE: mode_enable <= |wdata;
          IX_WIDTH:
            if (wdata <= 32'(MAX_W)) mode_width <= wdata[WB-1:0];
          IX_HEIGHT:
            if (wdata <= 32'(MAX_H)) mode_height <= wdata[HB-1:0];
          IX_BPP:
            if (wdata == 32'd8 || wdata == 32'd16 || wdata == 32'd24 ||
                wdata == 32'd32)
              mode_bpp <= wdata[5:0];
          IX_CFG:    config_done <= |wdata;
          IX_GUEST:  guest_q <= wdata;
          IX_CUR_ID: cursor_id <= wdata;
          IX_CUR_X:  cursor_x <= wdata;
          IX_CUR_Y:  cursor_y <= wdata;
          IX_CUR_ON: begin
            if (wdata == 32'd1) cursor_on <= 1'b1;
            else if (wdata == 32'd0) cursor_on <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign pitch = (32'(mode_bpp) * 32'(mode_width)) >> 3;

  always_comb begin
    case (idx)
      IX_ID:       rdata = id_q;
      IX_ENABLE:   rdata = {31'd0, mode_enable};
      IX_WIDTH:    rdata = 32'(mode_width);
      IX_HEIGHT:   rdata = 32'(mode_height);
      IX_MAXW:     rdata = 32'(MAX_W);
      IX_MAXH:     rdata = 32'(MAX_H);
      IX_DEPTH:    rdata = (mode_bpp == 6'd32) ? 32'd24 : 32'(mode_bpp);
      IX_BPP:      rdata = 32'(mode_bpp);
      IX_PITCH:    rdata = pitch;
      IX_CAPS:     rdata = CAP_WORD;
      IX_CFG:      rdata = {31'd0, config_done};
      IX_GUEST:    rdata = guest_q;
      IX_CUR_ID:   rdata = cursor_id;
      IX_CUR_X:    rdata = cursor_x;
      IX_CUR_Y:    rdata = cursor_y;
      IX_CUR_ON:   rdata = {31'd0, cursor_on};
      IX_SCR_SIZE: rdata = 32'(SCR_DEPTH);
      default:     rdata = 32'd0;
    endcase
  end

  assert_id_magic_R2: assert property (@(posedge clk) disable iff (rst)
    (id_q == MAGIC_V0 || id_q == MAGIC_V1 || id_q == MAGIC_V2));

  assert_width_limit_R3: assert property (@(posedge clk) disable iff (rst)
    32'(mode_width) <= 32'(MAX_W));

  assert_height_limit_R3: assert property (@(posedge clk) disable iff (rst)
    32'(mode_height) <= 32'(MAX_H));

  assert_bpp_legal_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_bpp == 6'd8 || mode_bpp == 6'd16 || mode_bpp == 6'd24 ||
     mode_bpp == 6'd32));

  assert_cursor_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IX_CUR_ON && wdata > 32'd1) |=> $stable(cursor_on));

  assert_sync_cause_R9: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> $past(wr_en && idx == IX_SYNC));

endmodule

// File: rtl/dispreg_port.sv
module dispreg_port
  import dispreg_pkg::*;
#(
  parameter int MAX_W     = 2368,
  parameter int MAX_H     = 1770,
  parameter int RST_W     = 640,
  parameter int RST_H     = 480,
  parameter int SCR_DEPTH = 64,
  localparam int WB = $clog2(MAX_W + 1),
  localparam int HB = $clog2(MAX_H + 1),
  localparam int SCR_AW = (SCR_DEPTH > 1) ? $clog2(SCR_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [1:0]    acc_offset,
  input  logic [31:0]   acc_wdata,
  output logic [31:0]   rd_data,
  output logic          rd_valid,
  output logic          mode_enable,
  output logic [WB-1:0] mode_width,
  output logic [HB-1:0] mode_height,
  output logic [5:0]    mode_bpp,
  output logic          config_done,
  output logic          sync_pulse,
  output logic          cursor_on,
  output logic [31:0]   cursor_id,
  output logic [31:0]   cursor_x,
  output logic [31:0]   cursor_y,
  output logic          bad_reg
);

  logic [31:0]       sel_q;
  reg_kind_e         kind;
  logic [SCR_AW-1:0] scr_addr;
  logic [31:0]       ctrl_rdata;
  logic [31:0]       ram_q;
  logic [31:0]       rd_q;
  logic              rd_from_ram;
  logic              data_acc, rd_acc;

  assign data_acc = acc_valid && (acc_offset == OFF_DATA);
  assign rd_acc   = acc_valid && !acc_write;

  dispreg_decode #(.SCR_DEPTH(SCR_DEPTH)) u_decode (
    .idx      (sel_q),
    .kind     (kind),
    .scr_addr (scr_addr)
  );

  dispreg_ctrl #(
    .MAX_W(MAX_W), .MAX_H(MAX_H), .RST_W(RST_W), .RST_H(RST_H),
    .SCR_DEPTH(SCR_DEPTH)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (data_acc && acc_write && kind == K_CTRL),
    .idx         (sel_q),
    .wdata       (acc_wdata),
    .rdata       (ctrl_rdata),
    .mode_enable (mode_enable),
    .mode_width  (mode_width),
    .mode_height (mode_height),
    .mode_bpp    (mode_bpp),
    .config_done (config_done),
    .sync_pulse  (sync_pulse),
    .cursor_on   (cursor_on),
    .cursor_id   (cursor_id),
    .cursor_x    (cursor_x),
    .cursor_y    (cursor_y)
  );

  dispreg_scratch #(.DEPTH(SCR_DEPTH), .DW(32)) u_scratch (
    .clk   (clk),
    .we    (data_acc && acc_write && kind == K_SCR),
    .addr  (scr_addr),
    .wdata (acc_wdata),
    .q     (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= '0;
      bad_reg     <= 1'b0;
      rd_valid    <= 1'b0;
      rd_q        <= '0;
      rd_from_ram <= 1'b0;
    end else begin
      if (acc_valid && acc_write && acc_offset == OFF_SEL)
        sel_q <= acc_wdata;
      if (data_acc && kind == K_BAD)
        bad_reg <= 1'b1;
      rd_valid    <= rd_acc;
      rd_from_ram <= rd_acc && data_acc && kind == K_SCR;
      if (rd_acc) begin
        case (acc_offset)
          OFF_SEL:  rd_q <= sel_q;
          OFF_DATA: rd_q <= (kind == K_CTRL) ? ctrl_rdata : 32'd0;
          OFF_BOOT: rd_q <= 32'd0;
          default:  rd_q <= 32'hFFFF_FFFF;
        endcase
      end
    end
  end

  assign rd_data = rd_from_ram ? ram_q : rd_q;

  assert_rd_follows_R1: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write));

  assert_sel_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_offset != OFF_SEL) |=> $stable(sel_q));

  assert_pal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (data_acc && kind == K_PAL) |=> $stable(bad_reg));

  assert_bad_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    !$fell(bad_reg));

endmodule

// File: tb/tb_dispreg_port.sv
module tb_dispreg_port;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 60;

  typedef struct packed {
    logic        rd;
    logic [1:0]  off;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // rd, offset, write data, expected read, requirement number
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 32'd0,          32'd0,          4'd2},  // R2 select id
    '{1'b1, 2'd1, 32'd0,          32'h9000_0002,  4'd2},
    '{1'b0, 2'd1, 32'h1234_5678,  32'd0,          4'd2},
    '{1'b1, 2'd1, 32'd0,          32'h9000_0002,  4'd2},  // R2 ignored
    '{1'b0, 2'd1, 32'h9000_0000,  32'd0,          4'd2},
    '{1'b1, 2'd1, 32'd0,          32'h9000_0000,  4'd2},
    '{1'b0, 2'd1, 32'h9000_0001,  32'd0,          4'd2},
    '{1'b1, 2'd1, 32'd0,          32'h9000_0001,  4'd2},
    '{1'b0, 2'd0, 32'd2,          32'd0,          4'd3},  // R3 width
    '{1'b0, 2'd1, 32'd800,        32'd0,          4'd3},
    '{1'b1, 2'd1, 32'd0,          32'd800,        4'd3},
    '{1'b0, 2'd1, 32'd2369,       32'd0,          4'd3},
    '{1'b1, 2'd1, 32'd0,          32'd800,        4'd3},  // R3 over limit
    '{1'b0, 2'd1, 32'd2368,       32'd0,          4'd3},
    '{1'b1, 2'd1, 32'd0,          32'd2368,       4'd3},  // R3 at limit
    '{1'b0, 2'd0, 32'd3,          32'd0,          4'd3},  // R3 height
    '{1'b0, 2'd1, 32'd1771,       32'd0,          4'd3},
    '{1'b1, 2'd1, 32'd0,          32'd480,        4'd3},
    '{1'b0, 2'd1, 32'd1770,       32'd0,          4'd3},
    '{1'b1, 2'd1, 32'd0,          32'd1770,       4'd3},
    '{1'b0, 2'd0, 32'd7,          32'd0,          4'd4},  // R4 bpp
    '{1'b0, 2'd1, 32'd16,         32'd0,          4'd4},
    '{1'b1, 2'd1, 32'd0,          32'd16,         4'd4},
    '{1'b0, 2'd1, 32'd17,         32'd0,          4'd4},
    '{1'b1, 2'd1, 32'd0,          32'd16,         4'd4},
    '{1'b0, 2'd0, 32'd6,          32'd0,          4'd4},
    '{1'b1, 2'd1, 32'd0,          32'd16,         4'd4},  // R4 depth=bpp
    '{1'b0, 2'd0, 32'd7,          32'd0,          4'd4},
    '{1'b0, 2'd1, 32'd32,         32'd0,          4'd4},
    '{1'b0, 2'd0, 32'd6,          32'd0,          4'd4},
    '{1'b1, 2'd1, 32'd0,          32'd24,         4'd4},  // R4 32 -> 24
    '{1'b0, 2'd0, 32'd2,          32'd0,          4'd5},  // R5 pitch
    '{1'b0, 2'd1, 32'd640,        32'd0,          4'd5},
    '{1'b0, 2'd0, 32'd12,         32'd0,          4'd5},
    '{1'b1, 2'd1, 32'd0,          32'd2560,       4'd5},
    '{1'b0, 2'd0, 32'd7,          32'd0,          4'd5},
    '{1'b0, 2'd1, 32'd24,         32'd0,          4'd5},
    '{1'b0, 2'd0, 32'd12,         32'd0,          4'd5},
    '{1'b1, 2'd1, 32'd0,          32'd1920,       4'd5},
    '{1'b0, 2'd0, 32'd27,         32'd0,          4'd6},  // R6 cursor
    '{1'b1, 2'd1, 32'd0,          32'd0,          4'd6},
    '{1'b0, 2'd1, 32'd1,          32'd0,          4'd6},
    '{1'b0, 2'd1, 32'd2,          32'd0,          4'd6},
    '{1'b1, 2'd1, 32'd0,          32'd1,          4'd6},
    '{1'b0, 2'd1, 32'd3,          32'd0,          4'd6},
    '{1'b1, 2'd1, 32'd0,          32'd1,          4'd6},
    '{1'b0, 2'd1, 32'd0,          32'd0,          4'd6},
    '{1'b0, 2'd1, 32'd3,          32'd0,          4'd6},
    '{1'b1, 2'd1, 32'd0,          32'd0,          4'd6},
    '{1'b0, 2'd0, 32'd17,         32'd0,          4'd10}, // R10 caps
    '{1'b1, 2'd1, 32'd0,          32'd3,          4'd10},
    '{1'b0, 2'd0, 32'd4,          32'd0,          4'd10},
    '{1'b1, 2'd1, 32'd0,          32'd2368,       4'd10},
    '{1'b0, 2'd0, 32'd29,         32'd0,          4'd10},
    '{1'b1, 2'd1, 32'd0,          32'd64,         4'd10},
    '{1'b1, 2'd0, 32'd0,          32'd29,         4'd1},  // R1 offsets
    '{1'b1, 2'd2, 32'd0,          32'd0,          4'd1},
    '{1'b1, 2'd3, 32'd0,          32'hFFFF_FFFF,  4'd1},
    '{1'b0, 2'd3, 32'd7,          32'd0,          4'd1},
    '{1'b1, 2'd0, 32'd0,          32'd29,         4'd1}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write;
  logic [1:0]  acc_offset;
  logic [31:0] acc_wdata;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        mode_enable;
  logic [11:0] mode_width;
  logic [10:0] mode_height;
  logic [5:0]  mode_bpp;
  logic        config_done, sync_pulse, cursor_on, bad_reg;
  logic [31:0] cursor_id, cursor_x, cursor_y;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dispreg_port dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .mode_enable(mode_enable), .mode_width(mode_width),
    .mode_height(mode_height), .mode_bpp(mode_bpp),
    .config_done(config_done), .sync_pulse(sync_pulse),
    .cursor_on(cursor_on), .cursor_id(cursor_id), .cursor_x(cursor_x),
    .cursor_y(cursor_y), .bad_reg(bad_reg)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access: driven for one cycle; results are due at the next falling edge.
  task automatic acc(input logic rd, input logic [1:0] off,
                     input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = !rd; acc_offset = off; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic wreg(input logic [31:0] ix, input logic [31:0] v);
    acc(1'b0, 2'd0, ix);
    acc(1'b0, 2'd1, v);
  endtask

  task automatic rreg(input string req, input logic [31:0] ix,
                      input logic [31:0] exp);
    acc(1'b0, 2'd0, ix);
    acc(1'b1, 2'd1, 32'd0);
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; acc_valid = 1'b0; acc_write = 1'b0;
    acc_offset = 2'd0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk("R12 width", 32'(mode_width), 32'd640);
    chk("R12 height", 32'(mode_height), 32'd480);
    chk("R12 bpp", 32'(mode_bpp), 32'd32);
    chk("R12 flags", {25'd0, mode_enable, config_done, sync_pulse,
                      cursor_on, bad_reg, rd_valid, 1'b0}, 32'd0);
    acc(1'b1, 2'd0, 32'd0);
    chk("R12 selector", rd_data, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].rd, VEC[i].off, VEC[i].data);
      if (VEC[i].rd) begin
        nchk++;
        if (rd_data !== VEC[i].exp) begin
          nerr++;
          $display("FAIL R%0d row %0d: actual=%h expected=%h",
                   VEC[i].req, i, rd_data, VEC[i].exp);
        end
      end
    end
    chk("R3 width port", 32'(mode_width), 32'd640);
    chk("R3 height port", 32'(mode_height), 32'd1770);
    chk("R4 bpp port", 32'(mode_bpp), 32'd24);
    chk("R6 cursor port", {31'd0, cursor_on}, 32'd0);

    // R7 scratch RAM, including the last entry
    wreg(32'd1792, 32'hA5A5_0001);
    wreg(32'd1793, 32'h0000_BEEF);
    wreg(32'd1855, 32'd77);
    rreg("R7 first", 32'd1792, 32'hA5A5_0001);
    rreg("R7 second", 32'd1793, 32'h0000_BEEF);
    rreg("R7 last", 32'd1855, 32'd77);

    // R8 palette window
    wreg(32'd1024, 32'd55);
    rreg("R8 low", 32'd1024, 32'd0);
    rreg("R8 high", 32'd1791, 32'd0);
    chk("R8 no flag", {31'd0, bad_reg}, 32'd0);

    // R11 undefined numbers, past-the-end scratch must not alias
    wreg(32'd1856, 32'd99);
    chk("R11 flag set", {31'd0, bad_reg}, 32'd1);
    rreg("R11 read zero", 32'd1856, 32'd0);
    rreg("R11 no alias", 32'd1792, 32'hA5A5_0001);
    wreg(32'd9, 32'd5);
    rreg("R11 hole", 32'd9, 32'd0);
    chk("R11 sticky", {31'd0, bad_reg}, 32'd1);

    // R9 sync strobe, config and enable
    wreg(32'd21, 32'd1);
    chk("R9 sync high", {31'd0, sync_pulse}, 32'd1);
    @(negedge clk);
    chk("R9 sync low", {31'd0, sync_pulse}, 32'd0);
    wreg(32'd20, 32'd5);
    chk("R9 config port", {31'd0, config_done}, 32'd1);
    rreg("R9 config read", 32'd20, 32'd1);
    wreg(32'd1, 32'd1);
    chk("R9 enable port", {31'd0, mode_enable}, 32'd1);
    wreg(32'd20, 32'd0);
    chk("R9 config clear", {31'd0, config_done}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule